// File: doc/BRIEF.md
# Single-Wire Byte Engine

This block moves whole bytes across an open-drain single-wire bus. Each bit travels in its own time slot, and the slot timing is counted in pulses of an external 1 µs tick. The host sees two byte-wide ports. A write port loads a holding register. A read port shows the most recently received byte. Three flags tell the host where data stands: the holding register is free (`tbe`), the shifter is idle (`temt`), and a received byte is waiting (`rbf`).

Every slot starts by pulling the line low. To send a one, the engine releases the line after a short pulse. To send a zero, it holds the line low for most of the slot. The engine samples the line partway through each slot. The sampled value is therefore the wired-AND of what the engine sent and what a slave drove. To read from a slave, the host sends 0xFF. If no slave answers, the engine receives back the byte it sent. There are two stages on each side: a holding register feeding a shifter on transmit, and a shifter feeding a buffer on receive. This lets the host queue the next byte while the current one is still on the wire.

Top module: `swire_byte_engine`

## Requirements
- R1: A one-cycle `host_wr` pulse stores `host_wdata` in the holding register, and `tbe` reads 0 from the next cycle on.
- R2: Whenever `temt`=1 and `tbe`=0, in the next cycle the byte moves into the shifter, so `temt` drops to 0 and `tbe` returns to 1.
- R3: Bits leave least significant first. For a 1 bit, `line_pull` stays high for exactly 6 ticks. For a 0 bit, it stays high for exactly 60 ticks.
- R4: Each slot spans 65 ticks. `line_pull` is low for at least the last 5 ticks of every slot.
- R5: The line is sampled 15 ticks into each slot, after a two-flop synchronizer on `line_in`. Each received bit therefore equals the sent bit ANDed with the slave's level, so an idle slave returns the sent byte.
- R6: When the eighth slot of a byte ends, the received byte appears on `rx_data`, `rbf` goes to 1 and `temt` returns to 1.
- R7: A `host_rd` pulse clears `rbf` in the next cycle. If a new byte completes in that same cycle, `rbf` stays at 1.
- R8: If a byte completes while `rbf` is still 1, the new byte replaces the one in the receive buffer.
- R9: After a synchronous active-low reset: `tbe`=1, `temt`=1, `rbf`=0, `rx_data`=0 and `line_pull`=0.
- R10: A slot starts only on a clock edge where `tick_us` is high. A host write during a slot does not change the byte already in the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| host_wr | input | 1 | Load strobe for the holding register |
| host_wdata | input | 8 | Byte to transmit |
| host_rd | input | 1 | Acknowledges the received byte and clears `rbf` |
| rx_data | output | 8 | Receive buffer contents |
| tbe | output | 1 | Holding register free |
| temt | output | 1 | Shifter idle |
| rbf | output | 1 | Receive buffer holds an unread byte |
| line_pull | output | 1 | Active-high pull-down enable for the bus |
| line_in | input | 1 | Bus level, asynchronous |

## Verification
The bench includes a slave model that holds the bus low for 30 ticks in every slot where its own bit is zero. A monitor turns each pull-down pulse back into a bit and checks the result against the byte that was sent. A shifter that sent the MSB first, or that miscounted the low phase, would produce a mismatched bit stream or a pulse length other than 6 or 60. The bench runs a byte of all zeros, which gives the shortest gaps between slots; a recovery window that is too short would show up as a gap below 5 ticks. It also sends 0xFF against a patterned slave and sends data against an idle slave. This exposes a receive path that sampled the sent bit in place of the line, or that sampled at the wrong tick. Finally, two bytes are sent without reading in between. A buffer that kept the first byte, or a flag that cleared itself, would fail the overwrite check.

// File: rtl/swire_pkg.sv
// Package: shared defaults and the engine state type for the single-wire
// byte engine. Assumes a tick of one microsecond supplied by the host.
package swire_pkg;
    localparam int unsigned DEF_DATA_W      = 8;
    localparam int unsigned DEF_LOW_TICKS   = 6;
    localparam int unsigned DEF_SAMPLE_TICK = 15;
    localparam int unsigned DEF_ZERO_TICKS  = 60;
    localparam int unsigned DEF_SLOT_TICKS  = 65;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_ARMED = 2'd1,
        ENG_SLOT  = 2'd2
    } eng_state_e;
endpackage

// File: rtl/swire_sync.sv
// Module: multi-stage synchronizer for the asynchronous bus level.
// Assumes STAGES >= 2. Resets to 1, the released (pulled-up) bus level.
module swire_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage_q;

    // First stage samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= 1'b1;
        else        stage_q[0] <= din;
    end

    // Remaining stages form the resolution chain.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[g] <= 1'b1;
            else        stage_q[g] <= stage_q[g-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/swire_tx_hold.sv
// Module: transmit holding register with its empty flag.
// Assumes the shifter pulls the byte with a single-cycle take strobe that
// is only raised while the register is full. A write in the same cycle as a
// take is kept; the take carries the older byte.
module swire_tx_hold #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              empty
);
    // Capture host byte and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
            empty     <= 1'b1;
        end else if (wr) begin
            hold_data <= wdata;
            empty     <= 1'b0;
        end else if (take) begin
            empty     <= 1'b1;
        end
    end

    AST_TBE_CLEARS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !empty); // R1
    AST_TAKE_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !empty); // R2
    AST_TAKE_FREES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr) |=> empty); // R2
endmodule

// File: rtl/swire_slot_engine.sv
// Module: transmit/receive shifters and the per-bit slot sequencer.
// Assumes tick is a one-cycle pulse every microsecond and line_sync is
// already synchronized. A slot begins on a tick, pulls the line low for
// LOW_TICKS (one) or ZERO_TICKS (zero), samples at SAMPLE_TICK and ends
// after SLOT_TICKS. The low phase is never cut short: nothing but reset
// leaves the SLOT state mid-slot.
module swire_slot_engine
    import swire_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned LOW_TICKS   = 6,
    parameter int unsigned SAMPLE_TICK = 15,
    parameter int unsigned ZERO_TICKS  = 60,
    parameter int unsigned SLOT_TICKS  = 65
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              line_sync,
    output logic              take,
    output logic              line_pull,
    output logic              temt,
    output logic              rx_done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int unsigned CNT_W = $clog2(SLOT_TICKS);
    localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT   = CNT_W'(SLOT_TICKS - 1);
    localparam logic [CNT_W-1:0] SAMPLE_CNT = CNT_W'(SAMPLE_TICK);
    localparam logic [CNT_W-1:0] LOW_CNT    = CNT_W'(LOW_TICKS);
    localparam logic [CNT_W-1:0] ZERO_CNT   = CNT_W'(ZERO_TICKS);
    localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(DATA_W - 1);

    eng_state_e        state_q;
    logic [DATA_W-1:0] tx_sh_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic [CNT_W-1:0]  slot_cnt_q;
    logic [CNT_W-1:0]  cnt_nx;
    logic [BIT_W-1:0]  bit_cnt_q;

    // Pull-down level for a given slot position and bit value.
    function automatic logic drive_low(input logic [CNT_W-1:0] pos, input logic bit_v);
        return (pos < LOW_CNT) || (!bit_v && (pos < ZERO_CNT));
    endfunction

    // Accept the held byte only while the shifter is idle.
    assign take    = (state_q == ENG_IDLE) && hold_full;
    assign temt    = (state_q == ENG_IDLE);
    assign cnt_nx  = slot_cnt_q + 1'b1;
    assign rx_byte = rx_sh_q;

    // Slot sequencer: load, wait for tick, run slots, shift bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ENG_IDLE;
            tx_sh_q    <= '0;
            rx_sh_q    <= '0;
            slot_cnt_q <= '0;
            bit_cnt_q  <= '0;
            line_pull  <= 1'b0;
            rx_done    <= 1'b0;
        end else begin
            rx_done <= 1'b0;
            unique case (state_q)
                ENG_IDLE: begin
                    if (take) begin
                        tx_sh_q   <= hold_data;
                        bit_cnt_q <= '0;
                        state_q   <= ENG_ARMED;
                    end
                end
                ENG_ARMED: begin
                    if (tick) begin
                        slot_cnt_q <= '0;
                        line_pull  <= 1'b1;
                        state_q    <= ENG_SLOT;
                    end
                end
                ENG_SLOT: begin
                    if (tick) begin
                        if (slot_cnt_q == LAST_CNT) begin
                            tx_sh_q <= tx_sh_q >> 1;
                            if (bit_cnt_q == LAST_BIT) begin
                                state_q <= ENG_IDLE;
                                rx_done <= 1'b1;
                            end else begin
                                bit_cnt_q  <= bit_cnt_q + 1'b1;
                                slot_cnt_q <= '0;
                                line_pull  <= 1'b1;
                            end
                        end else begin
                            slot_cnt_q <= cnt_nx;
                            line_pull  <= drive_low(cnt_nx, tx_sh_q[0]);
                            if (cnt_nx == SAMPLE_CNT)
                                rx_sh_q <= {line_sync, rx_sh_q[DATA_W-1:1]};
                        end
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    AST_LOAD_CLEARS_TEMT: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !temt); // R2
    AST_LOW_PHASE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_pull) |-> ((slot_cnt_q == LOW_CNT) || (slot_cnt_q == ZERO_CNT))); // R3
    AST_RECOVERY_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ENG_SLOT) && (slot_cnt_q >= ZERO_CNT)) |-> !line_pull); // R4
    AST_SLOT_STARTS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_pull) |-> $past(tick)); // R10
    AST_DONE_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> temt); // R6
endmodule

// File: rtl/swire_rx_hold.sv
// Module: receive buffer and its full flag.
// Assumes done is a one-cycle strobe with the new byte valid alongside.
// A completing byte wins over a same-cycle host read.
module swire_rx_hold #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] new_byte,
    input  logic              rd,
    output logic [DATA_W-1:0] buf_data,
    output logic              full
);
    // Latch completed bytes; host read acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_data <= '0;
            full     <= 1'b0;
        end else if (done) begin
            buf_data <= new_byte;
            full     <= 1'b1;
        end else if (rd) begin
            full     <= 1'b0;
        end
    end

    AST_RBF_SETS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> full); // R6
    AST_RBF_CLEARS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !done) |=> !full); // R7
    AST_OVERWRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (done && full) |=> (buf_data == $past(new_byte))); // R8
endmodule

// File: rtl/swire_byte_engine.sv
// Module: top of the single-wire byte engine. Wires the holding register,
// slot sequencer, synchronizer and receive buffer together.
// Assumes an external pull-up on the bus and a 1 us tick pulse.
module swire_byte_engine
    import swire_pkg::*;
#(
    parameter int unsigned DATA_W      = DEF_DATA_W,
    parameter int unsigned LOW_TICKS   = DEF_LOW_TICKS,
    parameter int unsigned SAMPLE_TICK = DEF_SAMPLE_TICK,
    parameter int unsigned ZERO_TICKS  = DEF_ZERO_TICKS,
    parameter int unsigned SLOT_TICKS  = DEF_SLOT_TICKS,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_us,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              tbe,
    output logic              temt,
    output logic              rbf,
    output logic              line_pull,
    input  logic              line_in
);
    logic [DATA_W-1:0] hold_data;
    logic [DATA_W-1:0] rx_byte;
    logic              take;
    logic              rx_done;
    logic              line_sync;

    swire_tx_hold #(.DATA_W(DATA_W)) u_tx_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (host_wr),
        .wdata     (host_wdata),
        .take      (take),
        .hold_data (hold_data),
        .empty     (tbe)
    );

    swire_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (line_in),
        .dout  (line_sync)
    );

    swire_slot_engine #(
        .DATA_W      (DATA_W),
        .LOW_TICKS   (LOW_TICKS),
        .SAMPLE_TICK (SAMPLE_TICK),
        .ZERO_TICKS  (ZERO_TICKS),
        .SLOT_TICKS  (SLOT_TICKS)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_us),
        .hold_full (!tbe),
        .hold_data (hold_data),
        .line_sync (line_sync),
        .take      (take),
        .line_pull (line_pull),
        .temt      (temt),
        .rx_done   (rx_done),
        .rx_byte   (rx_byte)
    );

    swire_rx_hold #(.DATA_W(DATA_W)) u_rx_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (rx_done),
        .new_byte (rx_byte),
        .rd       (host_rd),
        .buf_data (rx_data),
        .full     (rbf)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (tbe && temt && !rbf && !line_pull && (rx_data == '0))); // R9
endmodule

// File: tb/tb_swire_byte_engine.sv
module tb_swire_byte_engine;
    localparam int TICK_DIV = 3;
    localparam int SLAVE_LOW = 30;
    localparam int WDOG_LIMIT = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_us = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic       host_rd = 1'b0;
    logic [7:0] rx_data;
    logic       tbe, temt, rbf, line_pull;
    logic       line_in;
    logic       slave_low = 1'b0;

    int n_checks = 0;
    int n_fails = 0;
    int cyc = 0;
    int n_sent = 0;
    int mon_bit = 0;
    logic [7:0] tx_arr [0:63];
    logic [7:0] sl_arr [0:63];

    always #10 clk = ~clk;

    assign line_in = !(line_pull || slave_low);

    swire_byte_engine dut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rd(host_rd), .rx_data(rx_data),
        .tbe(tbe), .temt(temt), .rbf(rbf), .line_pull(line_pull), .line_in(line_in)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Tick source: one-cycle pulse every TICK_DIV clocks.
    int tdiv = 0;
    always @(negedge clk) begin
        tick_us = (tdiv == 0);
        tdiv = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    end

    // Slave model and line monitor.
    logic prev_pull = 1'b0;
    logic prev_tick = 1'b0;
    int low_ticks = 0;
    int gap_ticks = 0;
    bit have_gap = 1'b0;
    int slave_hold = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_pull = 1'b0; low_ticks = 0; gap_ticks = 0; have_gap = 1'b0;
            slave_hold = 0; slave_low = 1'b0;
        end else begin
            if (line_pull && !prev_pull) begin
                check(prev_tick, "R10 slot start on tick", 0, 1);
                if (have_gap)
                    check(gap_ticks >= 5, "R4 recovery ticks", gap_ticks, 5);
                low_ticks = 0;
                if (sl_arr[mon_bit / 8][mon_bit % 8] == 1'b0) slave_hold = SLAVE_LOW;
            end
            if (!line_pull && prev_pull) begin
                logic exp_bit;
                exp_bit = tx_arr[mon_bit / 8][mon_bit % 8];
                check(low_ticks == (exp_bit ? 6 : 60), "R3 low length / LSB-first bit",
                      low_ticks, exp_bit ? 6 : 60);
                mon_bit++;
                gap_ticks = 0;
                have_gap = 1'b1;
            end
            if (tick_us) begin
                if (line_pull) low_ticks++; else gap_ticks++;
                if (slave_hold > 0) slave_hold--;
            end
            slave_low = (slave_hold > 0);
            prev_pull = line_pull;
        end
        prev_tick = tick_us;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG_LIMIT) begin
            n_fails++; n_checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic send(input logic [7:0] tx, input logic [7:0] sl);
        while (!tbe) @(negedge clk);
        tx_arr[n_sent] = tx;
        sl_arr[n_sent] = sl;
        n_sent++;
        host_wr = 1'b1; host_wdata = tx;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic recv(input int idx);
        logic [7:0] exp;
        exp = tx_arr[idx] & sl_arr[idx];
        while (!rbf) @(negedge clk);
        check(rx_data == exp, "R5 R6 received byte", rx_data, exp);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        check(rbf == 1'b0, "R7 read clears rbf", rbf, 0);
    endtask

    task automatic wait_drained();
        while (!(tbe && temt && mon_bit == n_sent * 8)) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h1D5E_ED01));
        for (int i = 0; i < 64; i++) begin tx_arr[i] = 8'h00; sl_arr[i] = 8'hFF; end
        repeat (4) @(negedge clk);
        check(tbe && temt && !rbf && !line_pull && rx_data == 8'h00, "R9 reset state",
              {rx_data, 1'b0, tbe, temt, rbf, line_pull}, 8'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2: write then handoff timing.
        send(8'h00, 8'hFF);
        check(tbe == 1'b0 && temt == 1'b1, "R1 tbe clears after write", {tbe, temt}, 2'b01);
        @(negedge clk);
        check(tbe == 1'b1 && temt == 1'b0, "R2 handoff to shifter", {tbe, temt}, 2'b10);
        // R10: second write while the first byte is mid-slot.
        repeat (40) @(negedge clk);
        send(8'hFF, 8'hA5);
        check(tbe == 1'b0 && temt == 1'b0, "R10 byte held during slot", {tbe, temt}, 2'b00);
        recv(0);
        recv(1);
        // R5 idle slave echoes.
        send(8'h3C, 8'hFF);
        recv(2);
        // R8 overwrite: two bytes without a read.
        send(8'h96, 8'hFF);
        send(8'hFF, 8'h5A);
        wait_drained();
        check(rbf == 1'b1 && rx_data == 8'h5A, "R8 overwrite keeps newest",
              rx_data, 8'h5A);
        check(temt == 1'b1, "R6 temt set after last byte", temt, 1);
        host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
        check(rbf == 1'b0, "R7 read clears rbf", rbf, 0);

        // Random traffic, streamed back to back.
        for (int i = 0; i < 28; i++) begin
            logic [7:0] t, s;
            t = 8'($urandom);
            s = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom);
            if ($urandom % 3 == 0) t = 8'hFF;
            send(t, s);
            if (i > 0) recv(n_sent - 2);
        end
        recv(n_sent - 1);
        wait_drained();
        check(tbe && temt && !line_pull, "R6 idle after stream", {tbe, temt, line_pull}, 3'b110);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule